// File: doc/BRIEF.md
# Two-Wire Debug Link Entry Sequencer

This block sits on the programmer side of a two-wire program/debug link. The target's reset pin doubles as the link clock input. The target only enters its programming mode after a fixed sequence. First the data line is held high for longer than the target's minimum reset pulse. A burst of clock edges must then start before a hard deadline expires. From the fast system clock, the sequencer produces that sequence, the continuous link clock, and the direction control for a bidirectional data pin. It also holds a second, serially programmed device on the same fixture in reset, so that the shared receive wire stays free.

A `start` pulse begins entry. The pulse is refused when the divider setting would give a link clock slower than the minimum rate. If the first clock edge misses the deadline, the sequencer drops the data line, waits, and repeats the whole procedure. After a set number of repeats it gives up with `error`. Once `ready` is high, the clock runs without gaps until `stop` shuts the link down in a fixed order.

Top module: `pgm_link_entry`

## Requirements
- R1: After reset, `tgt_clk`, `tgt_dat_o`, `tgt_dat_oe`, `ready` and `error` are 0, and `aux_rst_n` is 1.
- R2: A `start` accepted at a clock edge causes the data line to be driven high. The line stays high, with `tgt_clk` low, for exactly `hold_cycles + half_period` system cycles before the first rising edge of `tgt_clk`.
- R3: `ready` rises exactly one system cycle after the 16th rising edge of `tgt_clk`. Through those 16 edges the data line is driven high and `ready` stays 0.
- R4: The first clock edge must arrive within DEADLINE_CYC system cycles after the data-high phase ends (DEADLINE_CYC = SYS_CLK_HZ × DEADLINE_NS / 1e9). Entry succeeds when `half_period` ≤ DEADLINE_CYC. Otherwise the clock stops and the data line is driven low for `hold_cycles + 1` cycles. A new data-high phase then follows.
- R5: After MAX_RETRIES restarts, the sequencer gives up, for MAX_RETRIES + 1 data-high phases in total. `error` goes to 1, the pins return to idle, and no further phases follow. The next accepted `start` clears `error`.
- R6: While `ready` is 1, `tgt_clk` runs with no gaps and a period of exactly `2 × half_period` system cycles. That period never exceeds SYS_CLK_HZ / MIN_LINK_HZ.
- R7: A `half_period` of 0, or one above SYS_CLK_HZ / (2 × MIN_LINK_HZ), sets `cfg_err` one cycle later. A `start` under such a setting is ignored: the pins stay idle and `ready` stays 0.
- R8: While `ready` is 1, `tgt_dat_oe` equals the inverse of `rx_turn` and `tgt_dat_o` equals `tx_bit`, both delayed by one cycle. During entry, `tgt_dat_oe` stays 1 whatever `rx_turn` is.
- R9: `aux_rst_n` is 0 whenever entry is in progress or `ready` is 1.
- R10: A `stop` while `ready` is 1 drops `ready` at once. One cycle later `tgt_clk` is 0. One cycle after that `tgt_dat_oe` is 0, and one cycle after that `aux_rst_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the entry procedure (taken only when idle) |
| stop | input | 1 | Shut down an active link |
| hold_cycles | input | HOLD_W | Data-high hold time in system cycles, minus one |
| half_period | input | DIV_W | Link clock half period in system cycles |
| tx_bit | input | 1 | Data bit to drive while active |
| rx_turn | input | 1 | Target is expected to drive; release the data pin |
| tgt_clk | output | 1 | Link clock to the target reset/clock pin |
| tgt_dat_o | output | 1 | Data value toward the target |
| tgt_dat_oe | output | 1 | Output enable of the data pin driver |
| aux_rst_n | output | 1 | Active-low reset for the co-located serial device |
| ready | output | 1 | Target is in programming mode |
| error | output | 1 | Entry abandoned after the retry limit |
| cfg_err | output | 1 | Divider setting out of range |

## Verification
The bench counts the exact length of the data-high, clock-low lead-in. A sequencer that starts the burst early, or holds the line for the wrong time, changes that count. The bench also counts edges up to `ready`, which catches a burst of 15 or 17 edges. A half period longer than the deadline drives the retry path. Here the bench counts data-high phases, the length of the low gap between them, and the final `error`, which would expose an off-by-one retry limit or a missing restart. Out-of-range dividers must leave the pins idle, and the shutdown order is checked cycle by cycle. A design that released the pin together with stopping the clock, or released the second device's reset too early, fails these checks.

// File: rtl/pgm_link_pkg.sv
package pgm_link_pkg;

    // Number of link clock rising edges that complete entry.
    localparam int unsigned BURST_EDGES = 16;
    localparam int unsigned EDGE_W      = $clog2(BURST_EDGES + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA_HIGH,
        ST_CLK_BURST,
        ST_ACTIVE,
        ST_RETRY_WAIT,
        ST_STOP_CLK,
        ST_STOP_REL
    } entry_state_e;

    // Per-state request for the pins; registered at the top.
    typedef struct packed {
        logic clk_run;
        logic dat_drv;
        logic dat_val;
        logic aux_rst_n;
    } pin_ctrl_t;

    function automatic longint unsigned deadline_cycles(
        input longint unsigned sys_hz,
        input longint unsigned win_ns
    );
        return (sys_hz * win_ns) / 64'd1_000_000_000;
    endfunction

    function automatic logic half_in_range(
        input longint unsigned half,
        input longint unsigned max_half
    );
        return (half != 0) && (half <= max_half);
    endfunction

endpackage

// File: rtl/pgm_down_timer.sv
module pgm_down_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/link_clk_divider.sv
module link_clk_divider #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             lclk,
    output logic             rise
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = (cnt == half - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            lclk <= 1'b0;
            rise <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            lclk <= ~lclk;
            rise <= ~lclk;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            rise <= 1'b0;
        end
    end
endmodule

// File: rtl/pgm_entry_fsm.sv
module pgm_entry_fsm
    import pgm_link_pkg::*;
#(
    parameter int unsigned          HOLD_W       = 16,
    parameter int unsigned          TMR_W        = 16,
    parameter int unsigned          MAX_RETRIES  = 3,
    parameter longint unsigned      DEADLINE_CYC = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_ok,
    input  logic              stop,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic              tx_bit,
    input  logic              rx_turn,
    input  logic              tmr_zero,
    input  logic              edge_rise,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    output pin_ctrl_t         ctrl,
    output logic              ready,
    output logic              error
);
    localparam int unsigned RETRY_W = $clog2(MAX_RETRIES + 2);

    entry_state_e       st, nxt;
    logic [EDGE_W-1:0]  edges;
    logic [RETRY_W-1:0] retries;
    logic               err_q;
    logic               retry_inc, retry_clr, err_set, err_clr, edge_clr;
    logic               first_missed, last_edge;

    assign first_missed = tmr_zero && (edges == '0) && !edge_rise;
    assign last_edge    = edge_rise && (edges == EDGE_W'(BURST_EDGES - 1));

    always_comb begin
        nxt       = st;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        retry_inc = 1'b0;
        retry_clr = 1'b0;
        err_set   = 1'b0;
        err_clr   = 1'b0;
        edge_clr  = 1'b0;
        case (st)
            ST_IDLE: begin
                if (start_ok) begin
                    nxt       = ST_DATA_HIGH;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(hold_cycles);
                    retry_clr = 1'b1;
                    err_clr   = 1'b1;
                end
            end
            ST_DATA_HIGH: begin
                if (tmr_zero) begin
                    nxt      = ST_CLK_BURST;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(DEADLINE_CYC);
                    edge_clr = 1'b1;
                end
            end
            ST_CLK_BURST: begin
                if (last_edge) begin
                    nxt = ST_ACTIVE;
                end else if (first_missed) begin
                    if (retries == RETRY_W'(MAX_RETRIES)) begin
                        nxt     = ST_IDLE;
                        err_set = 1'b1;
                    end else begin
                        nxt       = ST_RETRY_WAIT;
                        retry_inc = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(hold_cycles);
                    end
                end
            end
            ST_RETRY_WAIT: begin
                if (tmr_zero) begin
                    nxt      = ST_DATA_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(hold_cycles);
                end
            end
            ST_ACTIVE: begin
                if (stop) nxt = ST_STOP_CLK;
            end
            ST_STOP_CLK: nxt = ST_STOP_REL;
            ST_STOP_REL: nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ctrl = '{clk_run: 1'b0, dat_drv: 1'b0, dat_val: 1'b0, aux_rst_n: 1'b1};
        case (st)
            ST_DATA_HIGH:  ctrl = '{clk_run: 1'b0, dat_drv: 1'b1, dat_val: 1'b1, aux_rst_n: 1'b0};
            ST_CLK_BURST:  ctrl = '{clk_run: 1'b1, dat_drv: 1'b1, dat_val: 1'b1, aux_rst_n: 1'b0};
            ST_RETRY_WAIT: ctrl = '{clk_run: 1'b0, dat_drv: 1'b1, dat_val: 1'b0, aux_rst_n: 1'b0};
            ST_ACTIVE:     ctrl = '{clk_run: 1'b1, dat_drv: !rx_turn, dat_val: tx_bit, aux_rst_n: 1'b0};
            ST_STOP_CLK:   ctrl = '{clk_run: 1'b0, dat_drv: 1'b1, dat_val: 1'b1, aux_rst_n: 1'b0};
            ST_STOP_REL:   ctrl = '{clk_run: 1'b0, dat_drv: 1'b0, dat_val: 1'b0, aux_rst_n: 1'b0};
            default:       ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            edges   <= '0;
            retries <= '0;
            err_q   <= 1'b0;
        end else begin
            st <= nxt;
            if (edge_clr)
                edges <= '0;
            else if (edge_rise && st == ST_CLK_BURST)
                edges <= edges + EDGE_W'(1);
            if (retry_clr)
                retries <= '0;
            else if (retry_inc)
                retries <= retries + RETRY_W'(1);
            if (err_clr)
                err_q <= 1'b0;
            else if (err_set)
                err_q <= 1'b1;
        end
    end

    assign ready = (st == ST_ACTIVE);
    assign error = err_q;
endmodule

// File: rtl/pgm_link_entry.sv
module pgm_link_entry
    import pgm_link_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ  = 200_000_000,
    parameter int unsigned MIN_LINK_HZ = 10_000,
    parameter int unsigned DEADLINE_NS = 100_000,
    parameter int unsigned MAX_RETRIES = 3,
    parameter int unsigned HOLD_W      = 16,
    parameter int unsigned DIV_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic [DIV_W-1:0]  half_period,
    input  logic              tx_bit,
    input  logic              rx_turn,
    output logic              tgt_clk,
    output logic              tgt_dat_o,
    output logic              tgt_dat_oe,
    output logic              aux_rst_n,
    output logic              ready,
    output logic              error,
    output logic              cfg_err
);
    localparam longint unsigned DEADLINE_CYC = deadline_cycles(SYS_CLK_HZ, DEADLINE_NS);
    localparam int unsigned     MAX_HALF     = SYS_CLK_HZ / (2 * MIN_LINK_HZ);
    localparam int unsigned     DL_W         = $clog2(DEADLINE_CYC + 1);
    localparam int unsigned     TMR_W        = (DL_W > HOLD_W) ? DL_W : HOLD_W;

    logic             half_ok, start_ok;
    logic             tmr_load, tmr_zero, edge_rise;
    logic [TMR_W-1:0] tmr_val;
    pin_ctrl_t        ctrl;

    assign half_ok  = half_in_range(longint'(half_period), longint'(MAX_HALF));
    assign start_ok = start && half_ok;

    pgm_entry_fsm #(
        .HOLD_W       (HOLD_W),
        .TMR_W        (TMR_W),
        .MAX_RETRIES  (MAX_RETRIES),
        .DEADLINE_CYC (DEADLINE_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_ok    (start_ok),
        .stop        (stop),
        .hold_cycles (hold_cycles),
        .tx_bit      (tx_bit),
        .rx_turn     (rx_turn),
        .tmr_zero    (tmr_zero),
        .edge_rise   (edge_rise),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .ctrl        (ctrl),
        .ready       (ready),
        .error       (error)
    );

    pgm_down_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    link_clk_divider #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl.clk_run),
        .half (half_period),
        .lclk (tgt_clk),
        .rise (edge_rise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_dat_o  <= 1'b0;
            tgt_dat_oe <= 1'b0;
            aux_rst_n  <= 1'b1;
            cfg_err    <= 1'b0;
        end else begin
            tgt_dat_o  <= ctrl.dat_val;
            tgt_dat_oe <= ctrl.dat_drv;
            aux_rst_n  <= ctrl.aux_rst_n;
            cfg_err    <= !half_ok;
        end
    end
endmodule

// File: rtl/pgm_link_entry_chk.sv
module pgm_link_entry_chk #(
    parameter int unsigned MAX_HALF = 10000
) (
    input logic clk,
    input logic rst,
    input logic rx_turn,
    input logic tgt_clk,
    input logic tgt_dat_o,
    input logic tgt_dat_oe,
    input logic aux_rst_n,
    input logic ready,
    input logic error
);
    logic        clk_d;
    int unsigned stable_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_d      <= 1'b0;
            stable_len <= 0;
        end else begin
            clk_d <= tgt_clk;
            if (!ready || tgt_clk != clk_d)
                stable_len <= 0;
            else
                stable_len <= stable_len + 1;
        end
    end

    assert_entry_drives_high_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(tgt_dat_oe) && !ready) |-> tgt_dat_o);

    assert_ready_follows_edge_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(tgt_clk));

    assert_no_clock_gap_R6: assert property (@(posedge clk) disable iff (rst)
        ready |-> (stable_len < MAX_HALF));

    assert_no_ready_with_error_R5: assert property (@(posedge clk) disable iff (rst)
        !(ready && error));

    assert_release_on_turn_R8: assert property (@(posedge clk) disable iff (rst)
        (ready && !tgt_dat_oe) |-> $past(rx_turn));

    assert_aux_held_R9: assert property (@(posedge clk) disable iff (rst)
        ready |-> !aux_rst_n);

    assert_shutdown_order_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(aux_rst_n) |-> (!tgt_dat_oe && !tgt_clk));
endmodule

bind pgm_link_entry pgm_link_entry_chk #(.MAX_HALF(MAX_HALF)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_turn    (rx_turn),
    .tgt_clk    (tgt_clk),
    .tgt_dat_o  (tgt_dat_o),
    .tgt_dat_oe (tgt_dat_oe),
    .aux_rst_n  (aux_rst_n),
    .ready      (ready),
    .error      (error)
);

// File: tb/pgm_link_entry_tb.sv
module pgm_link_entry_tb;
    localparam int SYS_HZ    = 200_000_000;
    localparam int MIN_HZ    = 10_000;
    localparam int DL_NS     = 10_000;
    localparam int RETRIES   = 3;
    localparam int DL_CYC    = SYS_HZ / 1_000_000 * DL_NS / 1000;
    localparam int MAX_HALF  = SYS_HZ / (2 * MIN_HZ);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, stop = 1'b0, tx_bit = 1'b0, rx_turn = 1'b0;
    logic [15:0] hold_cycles = 16'd20;
    logic [15:0] half_period = 16'd5;
    logic        tgt_clk, tgt_dat_o, tgt_dat_oe, aux_rst_n, ready, error, cfg_err;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 0;

    int exp_q[$];
    int gap = 0;
    logic clk_prev = 1'b0;

    always #2.5 clk = ~clk;

    pgm_link_entry #(
        .SYS_CLK_HZ (SYS_HZ), .MIN_LINK_HZ (MIN_HZ),
        .DEADLINE_NS (DL_NS), .MAX_RETRIES (RETRIES)
    ) u_dut (
        .clk (clk), .rst (rst), .start (start), .stop (stop),
        .hold_cycles (hold_cycles), .half_period (half_period),
        .tx_bit (tx_bit), .rx_turn (rx_turn),
        .tgt_clk (tgt_clk), .tgt_dat_o (tgt_dat_o), .tgt_dat_oe (tgt_dat_oe),
        .aux_rst_n (aux_rst_n), .ready (ready), .error (error), .cfg_err (cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compares link clock periods against the expected queue.
    always @(negedge clk) begin
        if (!rst) begin
            if (tgt_clk && !clk_prev) begin
                if (ready && exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    chk(gap == e, "R6 period", gap, e);
                end
                gap = 1;
            end else begin
                gap++;
            end
            clk_prev = tgt_clk;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic entry_to_ready(input int hold, input int half, input bit turn_hi);
        int lead = 0, rises = 1, guard = 0;
        bit bad_hi = 0, bad_aux = 0, bad_rdy = 0;
        logic prev;
        hold_cycles = 16'(hold); half_period = 16'(half); rx_turn = turn_hi;
        @(negedge clk);
        pulse_start();
        while (!tgt_clk && guard < 50000) begin
            if (tgt_dat_oe && tgt_dat_o) lead++;
            if (tgt_dat_oe && aux_rst_n) bad_aux = 1;
            @(negedge clk); guard++;
        end
        chk(lead == hold + half, "R2 lead-in length", lead, hold + half);
        chk(error == 1'b0, "R5 error cleared by start", error, 0);
        prev = 1'b1;
        while (!ready && guard < 50000) begin
            @(negedge clk); guard++;
            if (!ready) begin
                if (tgt_clk && !prev) rises++;
                if (!(tgt_dat_oe && tgt_dat_o)) bad_hi = 1;
                if (rises > 16) bad_rdy = 1;
            end
            if (aux_rst_n) bad_aux = 1;
            prev = tgt_clk;
        end
        chk(rises == 16, "R3 edges before ready", rises, 16);
        chk(!bad_hi && !bad_rdy, "R3 data held high in burst", bad_hi, 0);
        chk(!bad_aux && !aux_rst_n, "R9 aux reset held low", aux_rst_n, 0);
        chk(!bad_hi, "R8 oe held during entry", bad_hi, 0);
    endtask

    task automatic stop_link();
        rx_turn = 1'b0;
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk(!ready, "R10 ready drops", ready, 0);
        @(negedge clk);
        chk(!tgt_clk && tgt_dat_oe && !aux_rst_n, "R10 step1 clock low", {tgt_clk, tgt_dat_oe, aux_rst_n}, 3'b010);
        @(negedge clk);
        chk(!tgt_dat_oe && !aux_rst_n, "R10 step2 pin released", {tgt_dat_oe, aux_rst_n}, 2'b00);
        @(negedge clk);
        chk(aux_rst_n, "R10 step3 aux released", aux_rst_n, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++; ntests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 idle state
        chk({tgt_clk, tgt_dat_o, tgt_dat_oe, ready, error} == 5'b0 && aux_rst_n,
            "R1 reset state", {tgt_clk, tgt_dat_o, tgt_dat_oe, ready, error, aux_rst_n}, 1);

        // R7 configuration range
        half_period = 16'(MAX_HALF + 1);
        @(negedge clk);
        chk(cfg_err, "R7 slow divider flagged", cfg_err, 1);
        pulse_start();
        repeat (4) @(negedge clk);
        chk(!tgt_dat_oe && aux_rst_n && !ready, "R7 start ignored (slow)", tgt_dat_oe, 0);
        half_period = 16'd0;
        @(negedge clk);
        chk(cfg_err, "R7 zero divider flagged", cfg_err, 1);
        pulse_start();
        repeat (4) @(negedge clk);
        chk(!tgt_dat_oe && aux_rst_n && !ready, "R7 start ignored (zero)", tgt_dat_oe, 0);
        half_period = 16'(MAX_HALF);
        @(negedge clk);
        chk(!cfg_err, "R7 limit divider accepted", cfg_err, 0);

        // R2 R3 R4(pass) R9 main entry
        entry_to_ready(20, 5, 1'b0);

        // R6 continuous clock via scoreboard
        for (int i = 0; i < 6; i++) exp_q.push_back(10);
        for (int g = 0; g < 400 && exp_q.size() > 0; g++) @(negedge clk);
        chk(exp_q.size() == 0, "R6 periods observed", exp_q.size(), 0);
        chk(2 * 5 <= SYS_HZ / MIN_HZ, "R6 minimum rate", 10, SYS_HZ / MIN_HZ);

        // R8 direction control
        @(negedge clk); rx_turn = 1'b1;
        @(negedge clk);
        chk(!tgt_dat_oe, "R8 released on turn", tgt_dat_oe, 0);
        rx_turn = 1'b0; tx_bit = 1'b1;
        @(negedge clk);
        chk(tgt_dat_oe && tgt_dat_o, "R8 drive one", {tgt_dat_oe, tgt_dat_o}, 3);
        tx_bit = 1'b0;
        @(negedge clk);
        chk(tgt_dat_oe && !tgt_dat_o, "R8 drive zero", {tgt_dat_oe, tgt_dat_o}, 2);

        // R10 shutdown order
        stop_link();

        // R4 R5 missed deadline and retry limit
        begin
            int pulses = 0, g = 0, gap_len = 0, first_gap = -1, after = 0;
            bit prev_hi = 0, in_gap = 0, clk_seen = 0;
            hold_cycles = 16'd10; half_period = 16'(DL_CYC + 1000);
            @(negedge clk);
            pulse_start();
            while (g < 60000 && after < 30) begin
                bit hi;
                hi = tgt_dat_oe && tgt_dat_o;
                if (hi && !prev_hi) pulses++;
                if (tgt_clk) clk_seen = 1;
                if (tgt_dat_oe && !tgt_dat_o) begin in_gap = 1; gap_len++; end
                else if (in_gap) begin
                    if (first_gap < 0) first_gap = gap_len;
                    in_gap = 0; gap_len = 0;
                end
                if (error) after++;
                prev_hi = hi;
                @(negedge clk); g++;
            end
            chk(!clk_seen, "R4 no edge before deadline", clk_seen, 0);
            chk(first_gap == 10 + 1, "R4 restart low gap", first_gap, 11);
            chk(pulses == RETRIES + 1, "R5 attempts before giving up", pulses, RETRIES + 1);
            chk(error && !ready, "R5 error raised", error, 1);
            chk(!tgt_dat_oe && aux_rst_n, "R5 pins idle after give-up", tgt_dat_oe, 0);
        end

        // R5 error cleared, R8 entry ignores rx_turn, then release in active
        entry_to_ready(12, 4, 1'b1);
        @(negedge clk);
        chk(!tgt_dat_oe, "R8 released in active", tgt_dat_oe, 0);
        stop_link();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule